// File: doc/BRIEF.md
# Frame Exchange Register Controller

This block is the register-side coordinator for a stop-and-wait frame exchange between a packet datapath and a host processor. A receive writer fills a receive frame buffer and pulses `rx_done` with the frame's word count and empty-byte count. If receive is enabled and the controller is open, it latches those counts into a status register, raises `irq`, and closes `rx_ready` so no further frame can enter the receive buffer.

The host reads status and writes any value to the status register to acknowledge, which drops `irq`. It then prepares a reply in the transmit buffer. To echo the frame, the transmit word count is the received count minus one, which drops the CRC word, and the empty count is copied. The host writes the control word with the transmit length and enables, then writes any value to the continue register. If transmit is enabled, the controller pulses `tx_start` and waits for `tx_done` before it reopens. Otherwise it reopens at once. Four configuration words give the local MAC address, IP address and control UDP port to the neighbouring filters.

Top module: `fbx_ctrl`

## Requirements
- R1: During and after reset, `irq`, `rx_ready` and `tx_start` are 0, and the control (word 0), status (word 1) and configuration words (4..7) read 0.
- R2: A frame is accepted only on a cycle where `rx_done` is 1 and `rx_ready` is 1. `rx_ready` is 1 only while the controller is open and control bit 30 (receive enable) is 1. A `rx_done` pulse at any other time leaves status and `irq` unchanged.
- R3: After the clock edge that accepts a frame, `irq` is 1 and status reads with bit 31 = 1, bits 17:16 = received empty count and bits 10:0 = received word count.
- R4: A write of any value to status word 1 clears `irq` and status bit 31 after that edge, and keeps the count fields.
- R5: If a status write and an accepted frame fall on the same edge, the new frame wins: `irq` stays 1 and status holds the new counts.
- R6: Control word 0 holds the transmit word count in bits 10:0, the transmit empty count in bits 17:16, receive enable in bit 30 and transmit enable in bit 31. Other bits read 0. `tx_words` and `tx_empty` follow the stored fields.
- R7: From the accepted frame until a continue write, `rx_ready` is 0 and further `rx_done` pulses are ignored.
- R8: A write to continue word 2 while holding, with transmit enable 1, gives a one-cycle `tx_start` pulse in the cycle after the write. `rx_ready` stays 0 until `tx_done`. After the edge that samples `tx_done`, transmit enable reads 0 and `rx_ready` follows receive enable.
- R9: A continue write while holding with transmit enable 0 gives no `tx_start` and reopens the controller after that edge.
- R10: A continue write while the controller is open or sending has no effect.
- R11: If `tx_done` and a control write fall on the same edge during sending, the written fields are stored but transmit enable reads 0.
- R12: Configuration words are MAC low 32 bits (4), MAC high 16 bits (5), IP address (6) and UDP port (7). The 16-bit words drop bits 31:16. `cfg_mac` is {word 5, word 4}. Word 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Receive-available interrupt |
| rx_ready | output | 1 | Receive writer may deliver a frame |
| rx_done | input | 1 | Receive writer finished a frame |
| rx_words | input | WORDS_W | Word count of the finished frame |
| rx_empty | input | EMPTY_W | Empty bytes in its last word |
| tx_start | output | 1 | One-cycle pulse that starts the transmit reader |
| tx_words | output | WORDS_W | Transmit word count |
| tx_empty | output | EMPTY_W | Transmit empty byte count |
| tx_done | input | 1 | Transmit reader finished |
| cfg_mac | output | 48 | Local MAC address |
| cfg_ip | output | 32 | Local IP address |
| cfg_udp_port | output | 16 | Control UDP port |

## Verification
Two pairs of events can fall on the same edge. In the first, the host's status acknowledge meets a new frame arriving. The bench provokes this by leaving an event unacknowledged, reopening without transmit, and then driving the status write and `rx_done` together. It expects `irq` to stay high with the new counts. In the second, the transmit reader's completion meets a host control write that sets transmit enable. The bench expects the other written fields to be stored but transmit enable to read 0. A behavioural model recomputes every output on every clock, so any priority slip shows up in the same cycle.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam int REG_W     = 32;
  localparam int EMPTY_LSB = 16;
  localparam int RXEN_BIT  = 30;
  localparam int TXEN_BIT  = 31;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_CONT = 2;
  localparam int A_CFG0 = 4;
  localparam int N_CFG  = 4;

  typedef enum logic [1:0] {ST_OPEN, ST_HOLD, ST_SEND} fbx_state_e;

  // flag31, flag30, empty field, word field -> register image
  function automatic logic [REG_W-1:0] fbx_pack(input logic f31, input logic f30,
                                               input logic [13:0] empty,
                                               input logic [15:0] words);
    fbx_pack = {f31, f30, empty, words};
  endfunction

  function automatic logic [15:0] fbx_words(input logic [REG_W-1:0] w);
    fbx_words = w[15:0];
  endfunction

  function automatic logic [13:0] fbx_empty(input logic [REG_W-1:0] w);
    fbx_empty = w[29:EMPTY_LSB];
  endfunction
endpackage

// File: rtl/fbx_cfg_regs.sv
module fbx_cfg_regs
  import fbx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic              rd_hit,
  output logic [REG_W-1:0]  rdata,
  output logic [47:0]       mac,
  output logic [31:0]       ip,
  output logic [15:0]       port
);
  logic [N_CFG*REG_W-1:0] cfg_flat;
  logic [N_CFG-1:0]       sel;

  for (genvar g = 0; g < N_CFG; g++) begin : g_word
    // even words are full width, odd words keep 16 bits
    localparam logic [REG_W-1:0] FMASK = (g % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [REG_W-1:0] q;
    assign sel[g] = (addr == ADDR_W'(A_CFG0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (wr_en && sel[g])  q <= wdata & FMASK;
    end
    assign cfg_flat[g*REG_W +: REG_W] = q;

    a_r12_cfg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[g]) |=> (q == ($past(wdata) & FMASK)));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CFG; i++)
      if (sel[i]) rdata = cfg_flat[i*REG_W +: REG_W];
  end
  assign rd_hit = |sel;

  assign mac  = {cfg_flat[1*REG_W +: 16], cfg_flat[0 +: REG_W]};
  assign ip   = cfg_flat[2*REG_W +: REG_W];
  assign port = cfg_flat[3*REG_W +: 16];
endmodule

// File: rtl/fbx_seq.sv
module fbx_seq
  import fbx_pkg::*;
#(
  parameter int WORDS_W = 11,
  parameter int EMPTY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               tx_en,
  input  logic               stat_wr,
  input  logic               cont_wr,
  input  logic               rx_done,
  input  logic [WORDS_W-1:0] rx_words,
  input  logic [EMPTY_W-1:0] rx_empty,
  input  logic               tx_done,
  output logic               rx_ready,
  output logic               irq,
  output logic [WORDS_W-1:0] stat_words,
  output logic [EMPTY_W-1:0] stat_empty,
  output logic               tx_start,
  output logic               tx_fin
);
  fbx_state_e state_q, state_d;
  logic       frame_acc;
  logic       release_hit;
  logic       pend_q;

  assign rx_ready    = (state_q == ST_OPEN) && rx_en;
  assign frame_acc   = rx_done && rx_ready;
  assign release_hit = cont_wr && (state_q == ST_HOLD);
  assign tx_fin      = tx_done && (state_q == ST_SEND);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN: if (frame_acc)   state_d = ST_HOLD;
      ST_HOLD: if (release_hit) state_d = tx_en ? ST_SEND : ST_OPEN;
      ST_SEND: if (tx_done)     state_d = ST_OPEN;
      default:                  state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OPEN;
      pend_q     <= 1'b0;
      stat_words <= '0;
      stat_empty <= '0;
      tx_start   <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_start <= release_hit && tx_en;
      // new frame outranks an acknowledge on the same edge
      if (frame_acc) begin
        pend_q     <= 1'b1;
        stat_words <= rx_words;
        stat_empty <= rx_empty;
      end else if (stat_wr) begin
        pend_q <= 1'b0;
      end
    end
  end
  assign irq = pend_q;

  a_r3_irq_only_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_acc));
  a_r4_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !frame_acc) |=> !irq);
  a_r5_frame_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && frame_acc) |=> irq);
  a_r7_closed_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_acc |=> !rx_ready);
  a_r8_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  a_r8_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(cont_wr && tx_en));
  a_r8_closed_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !rx_ready);
endmodule

// File: rtl/fbx_ctrl.sv
module fbx_ctrl
  import fbx_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int WORDS_W = 11,
  parameter int EMPTY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  output logic               rx_ready,
  input  logic               rx_done,
  input  logic [WORDS_W-1:0] rx_words,
  input  logic [EMPTY_W-1:0] rx_empty,
  output logic               tx_start,
  output logic [WORDS_W-1:0] tx_words,
  output logic [EMPTY_W-1:0] tx_empty,
  input  logic               tx_done,
  output logic [47:0]        cfg_mac,
  output logic [31:0]        cfg_ip,
  output logic [15:0]        cfg_udp_port
);
  logic               wr_ctrl, wr_stat, wr_cont;
  logic               ctrl_tx_en, ctrl_rx_en;
  logic [WORDS_W-1:0] ctrl_words;
  logic [EMPTY_W-1:0] ctrl_empty;
  logic [WORDS_W-1:0] stat_words;
  logic [EMPTY_W-1:0] stat_empty;
  logic               tx_fin;
  logic               cfg_hit;
  logic [REG_W-1:0]   cfg_rdata;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign wr_cont = reg_wr && (reg_addr == ADDR_W'(A_CONT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_tx_en <= 1'b0;
      ctrl_rx_en <= 1'b0;
      ctrl_words <= '0;
      ctrl_empty <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_tx_en <= reg_wdata[TXEN_BIT];
        ctrl_rx_en <= reg_wdata[RXEN_BIT];
        ctrl_words <= WORDS_W'(fbx_words(reg_wdata));
        ctrl_empty <= EMPTY_W'(fbx_empty(reg_wdata));
      end
      // completion of the transmit reader overrides the host's enable
      if (tx_fin) ctrl_tx_en <= 1'b0;
    end
  end
  assign tx_words = ctrl_words;
  assign tx_empty = ctrl_empty;

  fbx_seq #(.WORDS_W(WORDS_W), .EMPTY_W(EMPTY_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (ctrl_rx_en),
    .tx_en      (ctrl_tx_en),
    .stat_wr    (wr_stat),
    .cont_wr    (wr_cont),
    .rx_done    (rx_done),
    .rx_words   (rx_words),
    .rx_empty   (rx_empty),
    .tx_done    (tx_done),
    .rx_ready   (rx_ready),
    .irq        (irq),
    .stat_words (stat_words),
    .stat_empty (stat_empty),
    .tx_start   (tx_start),
    .tx_fin     (tx_fin)
  );

  fbx_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rd_hit (cfg_hit),
    .rdata  (cfg_rdata),
    .mac    (cfg_mac),
    .ip     (cfg_ip),
    .port   (cfg_udp_port)
  );

  always_comb begin
    if (cfg_hit)
      reg_rdata = cfg_rdata;
    else if (reg_addr == ADDR_W'(A_CTRL))
      reg_rdata = fbx_pack(ctrl_tx_en, ctrl_rx_en, 14'(ctrl_empty), 16'(ctrl_words));
    else if (reg_addr == ADDR_W'(A_STAT))
      reg_rdata = fbx_pack(irq, 1'b0, 14'(stat_empty), 16'(stat_words));
    else
      reg_rdata = '0;
  end

  a_r11_tx_en_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fin |=> !ctrl_tx_en);
  a_r9_no_start_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cont && !ctrl_tx_en) |=> !tx_start);
  a_r6_fields_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (tx_words == WORDS_W'($past(reg_wdata[15:0]))));
endmodule

// File: tb/sim_fbx_ctrl.sv
module sim_fbx_ctrl;
  localparam int ADDR_W = 3;
  localparam int WORDS_W = 11;
  localparam int EMPTY_W = 2;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, rx_ready, tx_start;
  logic rx_done = 1'b0;
  logic [WORDS_W-1:0] rx_words = '0;
  logic [EMPTY_W-1:0] rx_empty = '0;
  logic [WORDS_W-1:0] tx_words;
  logic [EMPTY_W-1:0] tx_empty;
  logic tx_done = 1'b0;
  logic [47:0] cfg_mac;
  logic [31:0] cfg_ip;
  logic [15:0] cfg_udp_port;

  int n_chk = 0;
  int n_err = 0;

  always #(TCK/2) clk = ~clk;

  fbx_ctrl #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W), .EMPTY_W(EMPTY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rx_ready(rx_ready),
    .rx_done(rx_done), .rx_words(rx_words), .rx_empty(rx_empty),
    .tx_start(tx_start), .tx_words(tx_words), .tx_empty(tx_empty), .tx_done(tx_done),
    .cfg_mac(cfg_mac), .cfg_ip(cfg_ip), .cfg_udp_port(cfg_udp_port));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_mode;        // 0 open, 1 waiting for host, 2 transmitting
  logic [31:0] m_ctrl;
  int          m_words, m_empty;
  bit          m_pend, m_txs;
  logic [31:0] m_cfg [4];

  always @(posedge clk or negedge rst_n) begin : model
    bit open_now, take, was_hold, en_tx;
    if (!rst_n) begin
      m_mode = 0; m_ctrl = 0; m_words = 0; m_empty = 0; m_pend = 0; m_txs = 0;
      foreach (m_cfg[k]) m_cfg[k] = 0;
    end else begin
      open_now = (m_mode == 0) && m_ctrl[30];
      take     = rx_done && open_now;
      was_hold = (m_mode == 1);
      en_tx    = m_ctrl[31];
      m_txs    = reg_wr && reg_addr == 2 && was_hold && en_tx;
      if (reg_wr && reg_addr == 1) m_pend = 0;
      if (take) begin m_pend = 1; m_words = rx_words; m_empty = rx_empty; end
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata & 32'hC003_07FF;
      if (m_mode == 2 && tx_done) begin m_ctrl[31] = 0; m_mode = 0; end
      else if (take) m_mode = 1;
      else if (was_hold && reg_wr && reg_addr == 2) m_mode = en_tx ? 2 : 0;
      if (reg_wr && reg_addr >= 4)
        m_cfg[reg_addr - 4] = reg_wdata & ((reg_addr % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    end
  end

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return {m_pend, 13'd0, 2'(m_empty), 5'd0, 11'(m_words)};
      4, 5, 6, 7: return m_cfg[a - 4];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    #4;
    if (rst_n) begin
      check("R3/R4 model irq", irq, m_pend);
      check("R2/R7 model rx_ready", rx_ready, (m_mode == 0) && m_ctrl[30]);
      check("R8 model tx_start", tx_start, m_txs);
      check("R6 model tx fields", {tx_words, tx_empty}, {m_ctrl[10:0], m_ctrl[17:16]});
      check("R12 model cfg", {cfg_mac, cfg_ip, cfg_udp_port},
            {m_cfg[1][15:0], m_cfg[0], m_cfg[2], m_cfg[3][15:0]});
      check("R6 model rdata", reg_rdata, m_read(int'(reg_addr)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #8; endtask
  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = d; tick(); reg_wr = 0;
  endtask
  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    reg_addr = ADDR_W'(a); #1; check(tag, reg_rdata, exp);
  endtask
  task automatic frame(input int w, input int e);
    rx_done = 1; rx_words = WORDS_W'(w); rx_empty = EMPTY_W'(e); tick(); rx_done = 0;
  endtask

  bit finished = 0;

  initial begin
    tick(); tick();
    check("R1 irq in reset", irq, 0);
    check("R1 rx_ready in reset", rx_ready, 0);
    check("R1 tx_start in reset", tx_start, 0);
    rst_n = 1; tick();
    rd_chk("R1 ctrl after reset", 0, 0);
    rd_chk("R1 status after reset", 1, 0);
    rd_chk("R1 cfg after reset", 6, 0);

    // R2: frame while receive disabled is ignored
    frame(9, 1);
    check("R2 irq stays low", irq, 0);
    rd_chk("R2 status unchanged", 1, 0);

    // R12 configuration words
    wr(4, 32'h5678_9ABC); wr(5, 32'hAB12_1234); wr(6, 32'h0102_0304); wr(7, 32'hFFFF_000B);
    wr(3, 32'hDEAD_BEEF);
    check("R12 mac", cfg_mac, 48'h1234_5678_9ABC);
    check("R12 ip", cfg_ip, 32'h0102_0304);
    check("R12 port", cfg_udp_port, 16'h000B);
    rd_chk("R12 hi word truncated", 5, 32'h0000_1234);
    rd_chk("R12 word 3 reads zero", 3, 0);

    // R2: enable receive
    wr(0, 32'h4000_0000);
    check("R2 rx_ready open", rx_ready, 1);
    // R10: continue while open has no effect
    wr(2, 32'h1);
    check("R10 no start", tx_start, 0);
    check("R10 still open", rx_ready, 1);

    // R3 frame accepted
    frame(25, 2);
    check("R3 irq", irq, 1);
    rd_chk("R3 status", 1, 32'h8002_0019);
    check("R7 closed", rx_ready, 0);
    frame(3, 3);
    rd_chk("R7 second frame ignored", 1, 32'h8002_0019);
    // R4 acknowledge
    wr(1, 32'h0);
    check("R4 irq cleared", irq, 0);
    rd_chk("R4 counts kept", 1, 32'h0002_0019);
    // R6 echo control word
    wr(0, 32'hC002_F818);
    check("R6 tx_words", tx_words, 11'd24);
    check("R6 tx_empty", tx_empty, 2'd2);
    rd_chk("R6 readback masked", 0, 32'hC002_0018);
    // R8 continue with transmit
    wr(2, 32'h0);
    check("R8 start pulse", tx_start, 1);
    check("R8 closed while sending", rx_ready, 0);
    tick();
    check("R8 pulse one cycle", tx_start, 0);
    wr(2, 32'h0);
    check("R10 continue while sending", tx_start, 0);
    tx_done = 1; tick(); tx_done = 0;
    check("R8 reopened", rx_ready, 1);
    rd_chk("R8 tx enable cleared", 0, 32'h4002_0018);

    // R9 continue without transmit
    frame(10, 0);
    wr(1, 0);
    wr(0, 32'h4000_0009);
    wr(2, 0);
    check("R9 no start", tx_start, 0);
    check("R9 reopened", rx_ready, 1);

    // R5 collision: pending event left unacknowledged, then ack + frame together
    frame(12, 3);
    wr(2, 0);
    check("R5 pending kept", irq, 1);
    reg_wr = 1; reg_addr = 1; rx_done = 1; rx_words = 7; rx_empty = 1;
    tick(); reg_wr = 0; rx_done = 0;
    check("R5 irq stays", irq, 1);
    rd_chk("R5 new counts", 1, 32'h8001_0007);

    // R11 completion collides with a control write
    wr(1, 0);
    wr(0, 32'hC000_0006);
    wr(2, 0);
    tick();
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'hC000_0005; tx_done = 1;
    tick(); reg_wr = 0; tx_done = 0;
    rd_chk("R11 enable cleared, fields stored", 0, 32'h4000_0005);
    check("R11 reopened", rx_ready, 1);

    tick(); tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule